// File: doc/BRIEF.md
# Raster timing and interrupt generator

This block produces the beam position for a small arcade-style video frame and the interrupts a CPU uses to pace itself to it. A fast master clock is divided down to a pixel advance strobe and a half-rate strobe. The horizontal counter advances on the pixel strobe, and the vertical counter advances each time the horizontal counter wraps. Horizontal and vertical blanking, the two syncs and a composite sync are decoded from these counters. Two 4-bit centering inputs move the sync pulses so that the picture can be repositioned on a monitor.

Three active-low interrupt requests come from the same counters. The first fires when vertical blanking begins. The second fires at the same point, but only in every other frame, and is paced by an odd/even frame flag. The third fires every 64 lines at a fixed phase. A 4-bit control register, written from a CPU bus, holds an enable for each request and a flip-screen flag. Each request is sticky: once raised, it stays low until software clears its enable bit, which releases it.

Top module: `raster_irq_top`

## Requirements
- R1: The master clock is divided by 2^PIX_DIV_LOG2 (default 8) to give the pixel advance strobe and by twice that (default 16) to give the half-rate strobe. The horizontal count rises by one on every pixel strobe.
- R2: `h_count` runs from 0 to 383 and then wraps to 0. `v_count` rises by one on each horizontal wrap and wraps from 261 to 0.
- R3: `hblank` is 0 for horizontal counts 14 to 253 and 1 otherwise. It is updated on the same edge as the counter.
- R4: `vblank` is 0 for lines 16 to 239 and 1 otherwise. It changes on the same edge as the line count.
- R5: `hsync_n` is a decode of the current counter with no added delay. It is low for counts 296+c to 327+c when `h_center[3]`=0, and for counts 281+c to 312+c when `h_center[3]`=1, where c = `h_center[2:0]`. With `h_center`=4'hF the window is 288 to 319.
- R6: `vsync_n` is low for lines 254-`v_center` to 261-`v_center`. `csync_n` is the XOR of `hsync_n` and `vsync_n`.
- R7: `odd_frame` toggles on the edge where line 239 ends. This is the same edge on which the count moves to line 240, count 0.
- R8: With control bit 1 set, `frame_irq_n` goes low on the edge where line 239 ends. It stays low until bit 1 is written 0, which releases it on the next clock and holds it high.
- R9: With control bit 0 set, `line_irq_n` goes low on the first half-rate strobe of any line whose count satisfies (count + 16) mod 64 = 0, that is lines 48, 112, 176 and 240. It stays low until bit 0 is 0, which releases it on the next half-rate strobe. Re-enabling the bit does not raise the request outside those lines.
- R10: With control bit 2 set, `alt_irq_n` goes low on a half-rate strobe during line 239, but only while `odd_frame` is 0. It stays low until bit 2 is 0, which releases it on the next half-rate strobe.
- R11: A write with `ctrl_we`=1 loads `ctrl_wdata` on that clock edge. Bit 0 enables the line request, bit 1 the frame request, bit 2 the alternate-frame request, and bit 3 drives `flip_screen`.
- R12: While `rst` is 1 on a clock edge, both counters go to 0, both blanks go to 1, `odd_frame` goes to 0, all control bits go to 0 and all three requests go high. Reset takes priority over a register write on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control register write data |
| h_center | input | 4 | Horizontal sync centering |
| v_center | input | 4 | Vertical sync centering |
| h_count | output | 9 | Horizontal position |
| v_count | output | 9 | Line number |
| hblank | output | 1 | Horizontal blanking, active high |
| vblank | output | 1 | Vertical blanking, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| odd_frame | output | 1 | Frame parity flag |
| flip_screen | output | 1 | Flip flag from control bit 3 |
| frame_irq_n | output | 1 | Per-frame request, active low |
| alt_irq_n | output | 1 | Every-other-frame request, active low |
| line_irq_n | output | 1 | Every-64-lines request, active low |

## Verification
The properties assume that `rst` is held for at least one clock edge before the counters are trusted. They also assume that the pixel and half-rate strobes keep a fixed phase to the line, which holds because a line is a whole number of half-rate periods. They place no constraint on the centering inputs, because those only shape the combinational sync decode. The stimulus changes centering values only while the counters are outside the window being checked, and writes the control register at line positions where no request edge is due. A single edge-driven expectation therefore applies to each check.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int CTRL_W        = 4;
  localparam int CTRL_LINE_EN  = 0;
  localparam int CTRL_FRAME_EN = 1;
  localparam int CTRL_ALT_EN   = 2;
  localparam int CTRL_FLIP     = 3;
  localparam int CENTER_W      = 4;

  typedef logic [CTRL_W-1:0] ctrl_t;
endpackage

// File: rtl/raster_clk_en.sv
module raster_clk_en #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  output logic pix_en,
  output logic half_en
);
  localparam int DW = DIV_LOG2 + 1;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign half_en = (div_q == '0);

  generate
    if (DIV_LOG2 == 0) begin : g_full_rate
      assign pix_en = 1'b1;
    end else begin : g_divided
      assign pix_en = (div_q[DIV_LOG2-1:0] == '0);
    end
  endgenerate
endmodule

// File: rtl/raster_counters.sv
module raster_counters #(
  parameter int H_TOTAL      = 384,
  parameter int V_TOTAL      = 262,
  parameter int HBLANK_END   = 13,
  parameter int HBLANK_START = 253,
  parameter int VBLANK_END   = 15,
  parameter int VBLANK_START = 239,
  parameter int HW           = $clog2(H_TOTAL),
  parameter int VW           = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] v_count,
  output logic          hblank,
  output logic          vblank,
  output logic          odd_frame
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_count   <= '0;
      v_count   <= '0;
      hblank    <= 1'b1;
      vblank    <= 1'b1;
      odd_frame <= 1'b0;
    end else if (pix_en) begin
      if (h_count == HW'(HBLANK_END))   hblank <= 1'b0;
      if (h_count == HW'(HBLANK_START)) hblank <= 1'b1;
      if (h_count == H_LAST) begin
        h_count <= '0;
        if (v_count == VW'(VBLANK_END)) vblank <= 1'b0;
        if (v_count == VW'(VBLANK_START)) begin
          vblank    <= 1'b1;
          odd_frame <= ~odd_frame;
        end
        v_count <= (v_count == V_LAST) ? '0 : v_count + 1'b1;
      end else begin
        h_count <= h_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/raster_sync.sv
module raster_sync
  import raster_pkg::*;
#(
  parameter int HW          = 9,
  parameter int VW          = 9,
  parameter int HSYNC_BEGIN = 296,
  parameter int HSYNC_LEN   = 32,
  parameter int HSYNC_EARLY = 8,
  parameter int VSYNC_BEGIN = 254,
  parameter int VSYNC_LEN   = 8
) (
  input  logic [HW-1:0]       h_count,
  input  logic [VW-1:0]       v_count,
  input  logic [CENTER_W-1:0] h_center,
  input  logic [CENTER_W-1:0] v_center,
  output logic                hsync_n,
  output logic                vsync_n,
  output logic                csync_n
);
  localparam int SW        = HW + 1;
  localparam int TW        = VW + 1;
  localparam int FINE_MAX  = (1 << (CENTER_W - 1)) - 1;
  localparam int LATE_LO   = HSYNC_BEGIN;
  localparam int EARLY_LO  = HSYNC_BEGIN - HSYNC_EARLY - FINE_MAX;

  logic [SW-1:0] hs_lo, hs_hi, h_ext;
  logic [TW-1:0] vs_lo, vs_hi, v_ext;
  logic [SW-1:0] fine;

  always_comb begin
    fine  = SW'(h_center[CENTER_W-2:0]);
    hs_lo = (h_center[CENTER_W-1] ? SW'(EARLY_LO) : SW'(LATE_LO)) + fine;
    hs_hi = hs_lo + SW'(HSYNC_LEN - 1);
    h_ext = SW'(h_count);
    vs_lo = TW'(VSYNC_BEGIN) - TW'(v_center);
    vs_hi = vs_lo + TW'(VSYNC_LEN - 1);
    v_ext = TW'(v_count);
  end

  assign hsync_n = !((h_ext >= hs_lo) && (h_ext <= hs_hi));
  assign vsync_n = !((v_ext >= vs_lo) && (v_ext <= vs_hi));
  assign csync_n = hsync_n ^ vsync_n;
endmodule

// File: rtl/raster_irq.sv
module raster_irq #(
  parameter int H_TOTAL              = 384,
  parameter int VBLANK_START         = 239,
  parameter int LINE_IRQ_PERIOD_LOG2 = 6,
  parameter int LINE_IRQ_PHASE       = 16,
  parameter int HW                   = 9,
  parameter int VW                   = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          half_en,
  input  logic [HW-1:0] h_count,
  input  logic [VW-1:0] v_count,
  input  logic          odd_frame,
  input  logic          line_en,
  input  logic          frame_en,
  input  logic          alt_en,
  output logic          frame_irq_n,
  output logic          alt_irq_n,
  output logic          line_irq_n
);
  localparam int P = LINE_IRQ_PERIOD_LOG2;

  logic [P-1:0] phase_sum;
  logic         line_hit;
  logic         vb_line;
  logic         frame_hit;

  assign phase_sum = v_count[P-1:0] + P'(LINE_IRQ_PHASE);
  assign line_hit  = (phase_sum == '0);
  assign vb_line   = (v_count == VW'(VBLANK_START));
  assign frame_hit = pix_en && vb_line && (h_count == HW'(H_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_irq_n <= 1'b1;
      alt_irq_n   <= 1'b1;
      line_irq_n  <= 1'b1;
    end else begin
      if (!frame_en)      frame_irq_n <= 1'b1;
      else if (frame_hit) frame_irq_n <= 1'b0;
      if (half_en) begin
        if (!line_en)       line_irq_n <= 1'b1;
        else if (line_hit)  line_irq_n <= 1'b0;
        if (!alt_en)                   alt_irq_n <= 1'b1;
        else if (vb_line && !odd_frame) alt_irq_n <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/raster_irq_top.sv
module raster_irq_top
  import raster_pkg::*;
#(
  parameter int PIX_DIV_LOG2         = 3,
  parameter int H_TOTAL              = 384,
  parameter int V_TOTAL              = 262,
  parameter int HBLANK_END           = 13,
  parameter int HBLANK_START         = 253,
  parameter int VBLANK_END           = 15,
  parameter int VBLANK_START         = 239,
  parameter int HSYNC_BEGIN          = 296,
  parameter int HSYNC_LEN            = 32,
  parameter int HSYNC_EARLY          = 8,
  parameter int VSYNC_BEGIN          = 254,
  parameter int VSYNC_LEN            = 8,
  parameter int LINE_IRQ_PERIOD_LOG2 = 6,
  parameter int LINE_IRQ_PHASE       = 16,
  parameter int HW                   = $clog2(H_TOTAL),
  parameter int VW                   = $clog2(V_TOTAL)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctrl_we,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  input  logic [CENTER_W-1:0] h_center,
  input  logic [CENTER_W-1:0] v_center,
  output logic [HW-1:0]       h_count,
  output logic [VW-1:0]       v_count,
  output logic                hblank,
  output logic                vblank,
  output logic                hsync_n,
  output logic                vsync_n,
  output logic                csync_n,
  output logic                odd_frame,
  output logic                flip_screen,
  output logic                frame_irq_n,
  output logic                alt_irq_n,
  output logic                line_irq_n
);
  logic  pix_en;
  logic  half_en;
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end

  assign flip_screen = ctrl_q[CTRL_FLIP];

  raster_clk_en #(.DIV_LOG2(PIX_DIV_LOG2)) u_clk_en (
    .clk(clk), .rst(rst), .pix_en(pix_en), .half_en(half_en)
  );

  raster_counters #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
    .HBLANK_END(HBLANK_END), .HBLANK_START(HBLANK_START),
    .VBLANK_END(VBLANK_END), .VBLANK_START(VBLANK_START),
    .HW(HW), .VW(VW)
  ) u_counters (
    .clk(clk), .rst(rst), .pix_en(pix_en),
    .h_count(h_count), .v_count(v_count),
    .hblank(hblank), .vblank(vblank), .odd_frame(odd_frame)
  );

  raster_sync #(
    .HW(HW), .VW(VW),
    .HSYNC_BEGIN(HSYNC_BEGIN), .HSYNC_LEN(HSYNC_LEN), .HSYNC_EARLY(HSYNC_EARLY),
    .VSYNC_BEGIN(VSYNC_BEGIN), .VSYNC_LEN(VSYNC_LEN)
  ) u_sync (
    .h_count(h_count), .v_count(v_count),
    .h_center(h_center), .v_center(v_center),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .csync_n(csync_n)
  );

  raster_irq #(
    .H_TOTAL(H_TOTAL), .VBLANK_START(VBLANK_START),
    .LINE_IRQ_PERIOD_LOG2(LINE_IRQ_PERIOD_LOG2), .LINE_IRQ_PHASE(LINE_IRQ_PHASE),
    .HW(HW), .VW(VW)
  ) u_irq (
    .clk(clk), .rst(rst), .pix_en(pix_en), .half_en(half_en),
    .h_count(h_count), .v_count(v_count), .odd_frame(odd_frame),
    .line_en(ctrl_q[CTRL_LINE_EN]), .frame_en(ctrl_q[CTRL_FRAME_EN]),
    .alt_en(ctrl_q[CTRL_ALT_EN]),
    .frame_irq_n(frame_irq_n), .alt_irq_n(alt_irq_n), .line_irq_n(line_irq_n)
  );
endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk #(
  parameter int H_TOTAL              = 384,
  parameter int V_TOTAL              = 262,
  parameter int HBLANK_END           = 13,
  parameter int HBLANK_START         = 253,
  parameter int VBLANK_START         = 239,
  parameter int LINE_IRQ_PERIOD_LOG2 = 6,
  parameter int LINE_IRQ_PHASE       = 16,
  parameter int HW                   = 9,
  parameter int VW                   = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic [HW-1:0] h_count,
  input logic [VW-1:0] v_count,
  input logic          hblank,
  input logic          odd_frame,
  input logic [3:0]    ctrl_q,
  input logic          frame_irq_n,
  input logic          alt_irq_n,
  input logic          line_irq_n
);
  localparam int P = LINE_IRQ_PERIOD_LOG2;
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [P-1:0]  LINE_TARGET = P'((1 << P) - LINE_IRQ_PHASE);

  // R2
  h_range_chk: assert property (@(posedge clk) disable iff (rst)
    (h_count <= H_LAST) && (v_count <= V_LAST));

  // R1
  h_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_en && h_count != H_LAST) |=> (h_count == $past(h_count) + 1'b1));

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_en && h_count == H_LAST && v_count == V_LAST) |=> (h_count == '0 && v_count == '0));

  // R3
  hblank_pos_chk: assert property (@(posedge clk) disable iff (rst)
    hblank == ((h_count > HW'(HBLANK_START)) || (h_count <= HW'(HBLANK_END))));

  // R7
  odd_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(odd_frame) |-> (v_count == VW'(VBLANK_START + 1) && h_count == '0));

  // R8
  frame_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_irq_n) |-> (v_count == VW'(VBLANK_START + 1) && h_count == '0 && $past(ctrl_q[1])));

  // R9
  line_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(line_irq_n) |-> (v_count[P-1:0] == LINE_TARGET && $past(ctrl_q[0])));

  // R10
  alt_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(alt_irq_n) |-> (v_count == VW'(VBLANK_START) && !odd_frame && $past(ctrl_q[2])));
endmodule

bind raster_irq_top raster_irq_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
  .HBLANK_END(HBLANK_END), .HBLANK_START(HBLANK_START),
  .VBLANK_START(VBLANK_START),
  .LINE_IRQ_PERIOD_LOG2(LINE_IRQ_PERIOD_LOG2), .LINE_IRQ_PHASE(LINE_IRQ_PHASE),
  .HW(HW), .VW(VW)
) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en),
  .h_count(h_count), .v_count(v_count), .hblank(hblank), .odd_frame(odd_frame),
  .ctrl_q(ctrl_q), .frame_irq_n(frame_irq_n), .alt_irq_n(alt_irq_n),
  .line_irq_n(line_irq_n)
);

// File: tb/test_raster_irq_top.sv
module test_raster_irq_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [3:0] ctrl_wdata = '0;
  logic [3:0] h_center = '0;
  logic [3:0] v_center = '0;
  logic [8:0] h_count, v_count;
  logic hblank, vblank, hsync_n, vsync_n, csync_n, odd_frame, flip_screen;
  logic frame_irq_n, alt_irq_n, line_irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // {h_center, h position, expected hsync_n}, ordered by position within one line
  localparam logic [13:0] HS_VEC [16] = '{
    {4'h8, 9'd280, 1'b1}, {4'h8, 9'd281, 1'b0}, {4'hF, 9'd287, 1'b1}, {4'hF, 9'd288, 1'b0},
    {4'h0, 9'd295, 1'b1}, {4'h0, 9'd296, 1'b0}, {4'h5, 9'd300, 1'b1}, {4'h5, 9'd301, 1'b0},
    {4'h8, 9'd312, 1'b0}, {4'h8, 9'd313, 1'b1}, {4'hF, 9'd319, 1'b0}, {4'hF, 9'd320, 1'b1},
    {4'h0, 9'd327, 1'b0}, {4'h0, 9'd328, 1'b1}, {4'h5, 9'd332, 1'b0}, {4'h5, 9'd333, 1'b1}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_irq_top #(.PIX_DIV_LOG2(0)) i_raster_irq_top (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .h_center(h_center), .v_center(v_center),
    .h_count(h_count), .v_count(v_count), .hblank(hblank), .vblank(vblank),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .csync_n(csync_n),
    .odd_frame(odd_frame), .flip_screen(flip_screen),
    .frame_irq_n(frame_irq_n), .alt_irq_n(alt_irq_n), .line_irq_n(line_irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (line %0d pos %0d)", req, act, exp, v_count, h_count);
    end
  endtask

  task automatic write_ctrl(input logic [3:0] d);
    ctrl_wdata = d;
    ctrl_we    = 1'b1;
    @(negedge clk);
    ctrl_we    = 1'b0;
  endtask

  task automatic wait_pos(input int v, input int h);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!(h_count == h && v_count == v) && guard < 200000);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0 cycles left", WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R12 reset state
    check("R12 h_count", h_count, 0);
    check("R12 v_count", v_count, 0);
    check("R12 hblank", hblank, 1);
    check("R12 vblank", vblank, 1);
    check("R12 odd_frame", odd_frame, 0);
    check("R12 frame_irq_n", frame_irq_n, 1);
    check("R12 alt_irq_n", alt_irq_n, 1);
    check("R12 line_irq_n", line_irq_n, 1);
    check("R12 flip", flip_screen, 0);

    rst = 1'b0;
    write_ctrl(4'h8);
    check("R11 flip bit3", flip_screen, 1);
    rst = 1'b1;
    idle(1);
    check("R12 flip cleared", flip_screen, 0);
    check("R12 h cleared", h_count, 0);
    ctrl_wdata = 4'hF;
    ctrl_we    = 1'b1;
    idle(1);
    ctrl_we    = 1'b0;
    check("R12 reset beats write", flip_screen, 0);
    rst = 1'b0;

    // R1 with a divide of 1, the count advances every clock
    idle(1);
    check("R1 step1", h_count, 1);
    idle(1);
    check("R1 step2", h_count, 2);

    write_ctrl(4'h7);
    check("R11 flip stays low", flip_screen, 0);

    // R5 sync windows for several centering values
    for (int i = 0; i < 16; i++) begin
      h_center = HS_VEC[i][13:10];
      wait_pos(0, int'(HS_VEC[i][9:1]));
      check("R5 hsync_n", hsync_n, int'(HS_VEC[i][0]));
    end
    h_center = 4'h0;

    // R3 blanking edges
    wait_pos(1, 13);  check("R3 hblank@13", hblank, 1);
    wait_pos(1, 14);  check("R3 hblank@14", hblank, 0);
    wait_pos(1, 253); check("R3 hblank@253", hblank, 0);
    wait_pos(1, 254); check("R3 hblank@254", hblank, 1);

    // R2 horizontal wrap
    wait_pos(1, 383);
    idle(1);
    check("R2 h wrap", h_count, 0);
    check("R2 v step", v_count, 2);

    // R4 vertical blank end
    wait_pos(15, 383); check("R4 vblank@15", vblank, 1);
    idle(1);           check("R4 vblank@16", vblank, 0);

    // R9 periodic request
    wait_pos(47, 383); check("R9 high before 48", line_irq_n, 1);
    wait_pos(48, 2);   check("R9 low at 48", line_irq_n, 0);
    check("R8 frame idle", frame_irq_n, 1);
    write_ctrl(4'h6);
    idle(3);           check("R9 released", line_irq_n, 1);
    wait_pos(50, 0);
    write_ctrl(4'h7);
    wait_pos(60, 0);   check("R9 no re-raise", line_irq_n, 1);
    wait_pos(112, 2);  check("R9 low at 112", line_irq_n, 0);
    write_ctrl(4'h6);
    idle(3);           check("R9 released again", line_irq_n, 1);

    // R10, R8, R7, R6 around vertical blank start
    wait_pos(200, 0);  check("R10 idle", alt_irq_n, 1);
    v_center = 4'hF;
    wait_pos(238, 0);  check("R6 vsync@238 c15", vsync_n, 1);
    wait_pos(238, 383);
    check("R10 high before 239", alt_irq_n, 1);
    check("R8 high before 240", frame_irq_n, 1);
    wait_pos(239, 4);
    check("R10 low at 239", alt_irq_n, 0);
    check("R6 vsync@239 c15", vsync_n, 0);
    wait_pos(239, 383);
    check("R8 still high", frame_irq_n, 1);
    check("R7 odd before", odd_frame, 0);
    check("R4 vblank@239", vblank, 0);
    idle(1);
    check("R8 low at 240", frame_irq_n, 0);
    check("R7 odd after", odd_frame, 1);
    check("R4 vblank@240", vblank, 1);
    wait_pos(242, 0);
    write_ctrl(4'h4);
    idle(3);           check("R8 released", frame_irq_n, 1);
    wait_pos(244, 0);
    write_ctrl(4'h6);
    wait_pos(246, 0);
    check("R8 held released", frame_irq_n, 1);
    check("R6 vsync@246 c15", vsync_n, 0);
    wait_pos(247, 0);
    check("R6 vsync@247 c15", vsync_n, 1);
    check("R10 sticky", alt_irq_n, 0);
    wait_pos(248, 0);
    write_ctrl(4'h2);
    idle(3);           check("R10 released", alt_irq_n, 1);
    v_center = 4'h0;

    wait_pos(253, 0);  check("R6 vsync@253", vsync_n, 1);
    wait_pos(254, 10);
    check("R6 vsync@254", vsync_n, 0);
    check("R6 csync h idle", csync_n, 1);
    wait_pos(254, 300);
    check("R6 csync both", csync_n, 0);
    wait_pos(261, 383); check("R6 vsync@261", vsync_n, 0);
    idle(1);
    check("R2 v wrap", v_count, 0);
    check("R2 h at wrap", h_count, 0);
    check("R6 vsync@0", vsync_n, 1);
    check("R4 vblank@0", vblank, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule